// File: doc/BRIEF.md
# Multi-Mode Pulse Width Count Timer

An 8-bit counter block with three uses. As a one-shot timer it counts down once from a programmed value, emits a single-cycle underflow pulse and halts. As a reload timer it counts down repeatedly, reloading on each underflow, and toggles its output into a square wave. As a measurement unit it times an input signal: a high or low width, a rising-to-rising or falling-to-falling period, or high width and period together. Each measurement runs either once or continuously.

The counter advances on a count tick. The tick comes from a prescaler that divides an instruction-cycle enable by 1, 4 or 32, or from rising edges of an external clock pin. The measured input and the external clock each pass through a two-flop synchroniser and an edge detector. Software programs the block through a small write port: a control register, a reload register and a command register. It reads the running count, the captured results, a sticky interrupt flag and a sticky overflow flag from registered outputs.

Top module: `pulse_width_timer`

## Requirements
- R1: After a synchronous reset, tout_o, irq_o, ovf_o and busy_o are 0, and count_o, cap_o and cap2_o are 0.
- R2: Control mode field (control bits [1:0]) 0 selects one-shot. A start command (address 2, bit 0) loads the reload value N (address 1). tout_o then pulses high for exactly one clock when the (N+1)-th count tick arrives. At the same time irq_o sets and busy_o drops, and no further pulse follows.
- R3: Mode 1 selects reload. tout_o starts low at the start command and toggles on every (N+1)-th count tick, without stopping.
- R4: Clock select (control bits [3:2]) 0, 1 and 2 give one count tick per 1, 4 and 32 instruction-cycle enables, counted from the start command. Value 3 gives one tick per rising edge of the synchronised ext_clk, and the instruction-cycle enable is then ignored.
- R5: Mode 2 selects measurement. Sub-mode (control bits [6:4]) 0 measures high width: the count restarts at 0 on a rising edge of meas_in, and the count reached at the falling edge (the width in ticks) is written to cap_o and sets irq_o.
- R6: Sub-mode 1 measures low width: the count starts at a falling edge and is captured at the next rising edge.
- R7: Sub-modes 2 and 3 measure rising-to-rising and falling-to-falling periods respectively. The captured value is the period in ticks.
- R8: Sub-mode 4 starts at a rising edge, captures the high width into cap_o at the falling edge, and captures the full period into cap2_o at the next rising edge. cap2_o changes only in this sub-mode.
- R9: Control bit 7 set gives continuous measurement: every later qualifying edge pair captures again. Clear gives single measurement: busy_o drops after the first capture and later edges leave the results unchanged.
- R10: A width or period of up to 255 ticks is captured exactly with ovf_o low. A longer interval saturates the count at 255 and sets ovf_o, which stays set until a clear command or a new start.
- R11: irq_o stays set until a command write with bit 2 set clears it (together with ovf_o). A new event in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 reload, 2 command |
| wr_data | input | 8 | Write data |
| inst_tick | input | 1 | Instruction-cycle enable feeding the prescaler |
| meas_in | input | 1 | Signal to measure (asynchronous) |
| ext_clk | input | 1 | External count clock (asynchronous) |
| tout_o | output | 1 | Timer output: underflow pulse or square wave |
| count_o | output | 8 | Current counter value |
| cap_o | output | 8 | Captured width or period |
| cap2_o | output | 8 | Captured period in the combined sub-mode |
| irq_o | output | 1 | Sticky interrupt flag |
| ovf_o | output | 1 | Sticky measurement overflow flag |
| busy_o | output | 1 | Timer or measurement active |

## Verification
The countdown modes are run with random reload values at all three internal divide ratios, plus the directed end values 0 and 255. This separates an off-by-one in the underflow point from an error in prescaler phase. Measurement is driven with random high and low segment lengths in every sub-mode, so a swapped start or end edge shows as the other segment's length or their sum. A second random pulse after a single measurement tells continuous operation from one-shot capture. Intervals of exactly 255 and of 300 ticks bracket the saturation point. An external-clock run with the instruction enable held low shows that ticks come only from the pin.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  typedef enum logic [1:0] {
    MODE_ONESHOT = 2'd0,
    MODE_RELOAD  = 2'd1,
    MODE_MEASURE = 2'd2,
    MODE_SPARE   = 2'd3
  } pwt_mode_e;

  typedef logic [2:0] pwt_sub_t;
  localparam pwt_sub_t SUB_HIGH  = 3'd0;
  localparam pwt_sub_t SUB_LOW   = 3'd1;
  localparam pwt_sub_t SUB_RISE  = 3'd2;
  localparam pwt_sub_t SUB_FALL  = 3'd3;
  localparam pwt_sub_t SUB_COMBO = 3'd4;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_CMD    = 2'd2;

  localparam int CMD_START = 0;
  localparam int CMD_STOP  = 1;
  localparam int CMD_CLEAR = 2;

  typedef struct packed {
    logic      cont;
    pwt_sub_t  sub;
    logic [1:0] csel;
    pwt_mode_e mode;
  } pwt_ctrl_t;
endpackage

// File: rtl/pwt_sync_edge.sv
module pwt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~prev;
  assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/pwt_prescale.sv
module pwt_prescale #(
  parameter int DIV_MID  = 4,
  parameter int DIV_SLOW = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       inst_tick,
  input  logic [1:0] csel,
  input  logic       ext_rise,
  output logic       tick_o
);
  localparam int PW = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;

  logic [PW-1:0] phase;
  logic [PW-1:0] limit;

  always_comb begin
    case (csel)
      2'd0:    limit = '0;
      2'd1:    limit = PW'(DIV_MID - 1);
      default: limit = PW'(DIV_SLOW - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase <= '0;
    end else if (inst_tick) begin
      phase <= (phase >= limit) ? '0 : phase + 1'b1;
    end
  end

  assign tick_o = (csel == 2'd3) ? ext_rise : (inst_tick && (phase >= limit));
endmodule

// File: rtl/pwt_core.sv
module pwt_core
  import pwt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         stop,
  input  logic         clear,
  input  pwt_mode_e    mode,
  input  pwt_sub_t     sub,
  input  logic         cont,
  input  logic [W-1:0] reload,
  input  logic         tick,
  input  logic         rise,
  input  logic         fall,
  output logic         tout_o,
  output logic [W-1:0] count_o,
  output logic [W-1:0] cap_o,
  output logic [W-1:0] cap2_o,
  output logic         irq_o,
  output logic         ovf_o,
  output logic         busy_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         run, meas, hi_done;
  logic         st_e, en_e, mid_e, period_mode;
  logic [W-1:0] cnt_inc;
  logic         sat_hit;

  always_comb begin
    st_e  = rise;
    en_e  = fall;
    mid_e = 1'b0;
    case (sub)
      SUB_LOW:   begin st_e = fall; en_e = rise; end
      SUB_RISE:  en_e = rise;
      SUB_FALL:  begin st_e = fall; en_e = fall; end
      SUB_COMBO: begin en_e = rise; mid_e = fall & ~hi_done; end
      default:   ;
    endcase
  end

  assign period_mode = (sub == SUB_RISE) || (sub == SUB_FALL) || (sub == SUB_COMBO);
  assign sat_hit     = tick && (count_o == MAXV);
  assign cnt_inc     = (tick && (count_o != MAXV)) ? count_o + 1'b1 : count_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      meas    <= 1'b0;
      hi_done <= 1'b0;
      tout_o  <= 1'b0;
      count_o <= '0;
      cap_o   <= '0;
      cap2_o  <= '0;
      irq_o   <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      if (mode == MODE_ONESHOT) tout_o <= 1'b0;
      if (clear) begin
        irq_o <= 1'b0;
        ovf_o <= 1'b0;
      end
      if (start) begin
        run     <= 1'b1;
        meas    <= 1'b0;
        hi_done <= 1'b0;
        tout_o  <= 1'b0;
        ovf_o   <= 1'b0;
        count_o <= (mode == MODE_MEASURE) ? '0 : reload;
      end else if (stop) begin
        run  <= 1'b0;
        meas <= 1'b0;
      end else if (run) begin
        if (mode != MODE_MEASURE) begin
          if (tick) begin
            if (count_o == '0) begin
              irq_o <= 1'b1;
              if (mode == MODE_ONESHOT) begin
                tout_o <= 1'b1;
                run    <= 1'b0;
              end else begin
                tout_o  <= ~tout_o;
                count_o <= reload;
              end
            end else begin
              count_o <= count_o - 1'b1;
            end
          end
        end else if (meas && en_e) begin
          if (sub == SUB_COMBO) cap2_o <= cnt_inc;
          else                  cap_o  <= cnt_inc;
          irq_o <= 1'b1;
          if (sat_hit) ovf_o <= 1'b1;
          if (cont && period_mode) begin
            count_o <= '0;
            hi_done <= 1'b0;
          end else begin
            meas    <= 1'b0;
            count_o <= cnt_inc;
            if (!cont) run <= 1'b0;
          end
        end else if (meas) begin
          if (mid_e) begin
            cap_o   <= cnt_inc;
            irq_o   <= 1'b1;
            hi_done <= 1'b1;
          end
          count_o <= cnt_inc;
          if (sat_hit) ovf_o <= 1'b1;
        end else if (st_e) begin
          meas    <= 1'b1;
          hi_done <= 1'b0;
          count_o <= '0;
        end
      end
    end
  end

  assign busy_o = run;
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer
  import pwt_pkg::*;
#(
  parameter int W           = 8,
  parameter int DIV_MID     = 4,
  parameter int DIV_SLOW    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [7:0]   wr_data,
  input  logic         inst_tick,
  input  logic         meas_in,
  input  logic         ext_clk,
  output logic         tout_o,
  output logic [W-1:0] count_o,
  output logic [W-1:0] cap_o,
  output logic [W-1:0] cap2_o,
  output logic         irq_o,
  output logic         ovf_o,
  output logic         busy_o
);
  pwt_ctrl_t    ctrl_q;
  logic [W-1:0] reload_q;
  logic         cmd_wr, do_start, do_stop, do_clear;
  logic         m_lvl, m_rise, m_fall;
  logic         e_lvl, e_rise, e_fall;
  logic         cnt_tick;
  logic [1:0]   mode_w;
  logic [2:0]   sub_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL)   ctrl_q   <= pwt_ctrl_t'(wr_data);
      if (wr_addr == ADDR_RELOAD) reload_q <= W'(wr_data);
    end
  end

  assign cmd_wr   = wr_en && (wr_addr == ADDR_CMD);
  assign do_start = cmd_wr && wr_data[CMD_START];
  assign do_stop  = cmd_wr && wr_data[CMD_STOP];
  assign do_clear = cmd_wr && wr_data[CMD_CLEAR];
  assign mode_w   = ctrl_q.mode;
  assign sub_w    = ctrl_q.sub;

  pwt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_meas (
    .clk(clk), .rst(rst), .din(meas_in),
    .level_o(m_lvl), .rise_o(m_rise), .fall_o(m_fall)
  );

  pwt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_ext (
    .clk(clk), .rst(rst), .din(ext_clk),
    .level_o(e_lvl), .rise_o(e_rise), .fall_o(e_fall)
  );

  pwt_prescale #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_pre (
    .clk(clk), .rst(rst), .restart(do_start), .inst_tick(inst_tick),
    .csel(ctrl_q.csel), .ext_rise(e_rise), .tick_o(cnt_tick)
  );

  pwt_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .start(do_start), .stop(do_stop), .clear(do_clear),
    .mode(ctrl_q.mode), .sub(ctrl_q.sub), .cont(ctrl_q.cont), .reload(reload_q),
    .tick(cnt_tick), .rise(m_rise), .fall(m_fall),
    .tout_o(tout_o), .count_o(count_o), .cap_o(cap_o), .cap2_o(cap2_o),
    .irq_o(irq_o), .ovf_o(ovf_o), .busy_o(busy_o)
  );
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [7:0]   wr_data,
  input logic         tout_o,
  input logic [W-1:0] count_o,
  input logic [W-1:0] cap_o,
  input logic [W-1:0] cap2_o,
  input logic         irq_o,
  input logic         ovf_o,
  input logic         busy_o,
  input logic [1:0]   mode,
  input logic [2:0]   sub
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_addr == 2'd2) && wr_data[2];

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && !busy_o && !tout_o && !ovf_o));

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && tout_o) |=> !tout_o);

  assert_rise_flags_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(tout_o) |-> irq_o);

  assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clr_wr) |=> irq_o);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> (count_o == {W{1'b1}} || cap_o == {W{1'b1}}));

  assert_period_combo_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap2_o) |-> (sub == 3'd4));
endmodule

bind pulse_width_timer pwt_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tout_o(tout_o), .count_o(count_o), .cap_o(cap_o), .cap2_o(cap2_o),
  .irq_o(irq_o), .ovf_o(ovf_o), .busy_o(busy_o), .mode(mode_w), .sub(sub_w)
);

// File: tb/pulse_width_timer_bench.sv
`timescale 1ns/1ps
module pulse_width_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       inst_tick = 1'b1;
  logic       meas_in = 1'b0;
  logic       ext_clk = 1'b0;
  logic       tout_o, irq_o, ovf_o, busy_o;
  logic [7:0] count_o, cap_o, cap2_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pulse_width_timer u_pulse_width_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .inst_tick(inst_tick), .meas_in(meas_in), .ext_clk(ext_clk),
    .tout_o(tout_o), .count_o(count_o), .cap_o(cap_o), .cap2_o(cap2_o),
    .irq_o(irq_o), .ovf_o(ovf_o), .busy_o(busy_o)
  );

  function automatic int div_of(input int csel);
    return (csel == 0) ? 1 : (csel == 1) ? 4 : 32;
  endfunction

  function automatic int exp_delay(input int csel, input int n);
    return div_of(csel) * (n + 1);
  endfunction

  function automatic int sat8(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tout(input int limit, output int k);
    int cnt;
    bit found;
    cnt = 0; found = 0;
    while (!found && cnt < limit) begin
      @(negedge clk);
      cnt++;
      if (tout_o) found = 1;
    end
    k = found ? cnt : -1;
  endtask

  task automatic oneshot(input int csel, input int n);
    int k;
    wr(2'd2, 8'h06);
    wr(2'd1, n[7:0]);
    wr(2'd0, {1'b0, 3'd0, csel[1:0], 2'd0});
    wr(2'd2, 8'h01);
    wait_tout(10000, k);
    chk("R2/R4 underflow delay", k, exp_delay(csel, n));
    @(negedge clk);
    chk("R2 pulse width", tout_o, 0);
    chk("R2 irq", irq_o, 1);
    chk("R2 halted", busy_o, 0);
  endtask

  task automatic meas_setup(input int sub, input bit cont, input bit idle);
    wr(2'd2, 8'h02);
    meas_in = idle;
    tick_n(6);
    wr(2'd2, 8'h04);
    wr(2'd0, {cont, sub[2:0], 2'd0, 2'd2});
    wr(2'd2, 8'h01);
    tick_n(2);
  endtask

  task automatic seg(input bit lvl, input int n);
    meas_in = lvl;
    tick_n(n);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, h, l, h2, ex, k, t1, t2, t3, cnt, togs;
    bit prev;
    void'($urandom(32'd20240611));
    tick_n(4);
    rst = 1'b0;
    tick_n(2);
    chk("R1 tout", tout_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 cap", cap_o, 0);
    chk("R1 cap2", cap2_o, 0);

    // R2 directed ends and random reload values
    oneshot(0, 0);
    oneshot(0, 255);
    for (int i = 0; i < 4; i++) oneshot(0, $urandom_range(1, 60));
    cnt = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (tout_o) cnt++; end
    chk("R2 no second pulse", cnt, 0);
    // R4 internal divide ratios
    for (int i = 0; i < 3; i++) oneshot(1, $urandom_range(0, 20));
    for (int i = 0; i < 2; i++) oneshot(2, $urandom_range(0, 7));

    // R11 clear
    chk("R11 irq before clear", irq_o, 1);
    wr(2'd2, 8'h04);
    chk("R11 irq cleared", irq_o, 0);

    // R3 reload square wave
    for (int r = 0; r < 3; r++) begin
      n = $urandom_range(1, 25);
      wr(2'd2, 8'h06);
      wr(2'd1, n[7:0]);
      wr(2'd0, 8'h01);
      wr(2'd2, 8'h01);
      prev = 0; cnt = 0; togs = 0; t1 = 0; t2 = 0; t3 = 0;
      while (togs < 3 && cnt < 2000) begin
        @(negedge clk);
        cnt++;
        if (tout_o != prev) begin
          togs++;
          if (togs == 1) t1 = cnt;
          if (togs == 2) t2 = cnt;
          if (togs == 3) t3 = cnt;
        end
        prev = tout_o;
      end
      chk("R3 first toggle", t1, n + 1);
      chk("R3 toggle period a", t2 - t1, n + 1);
      chk("R3 toggle period b", t3 - t2, n + 1);
      chk("R3 still running", busy_o, 1);
    end

    // R4 external clock, instruction enable held low
    wr(2'd2, 8'h06);
    inst_tick = 1'b0;
    wr(2'd1, 8'd3);
    wr(2'd0, 8'h0C);
    wr(2'd2, 8'h01);
    for (int i = 0; i < 3; i++) begin ext_clk = 1; tick_n(3); ext_clk = 0; tick_n(3); end
    tick_n(6);
    chk("R4 ext three edges no underflow", irq_o, 0);
    ext_clk = 1; tick_n(3); ext_clk = 0; tick_n(6);
    chk("R4 ext fourth edge underflow", irq_o, 1);
    chk("R4 ext halted", busy_o, 0);
    inst_tick = 1'b1;

    // R5 high width, single
    for (int i = 0; i < 4; i++) begin
      h = $urandom_range(1, 250);
      meas_setup(0, 0, 0);
      seg(1, h); seg(0, 6);
      chk("R5 high width", cap_o, h);
      chk("R5 irq", irq_o, 1);
    end
    // R9 single: later pulse ignored
    h2 = h + 3;
    seg(1, h2); seg(0, 6);
    chk("R9 single keeps result", cap_o, h);
    chk("R9 single halted", busy_o, 0);
    // R9 continuous high width
    meas_setup(0, 1, 0);
    for (int i = 0; i < 3; i++) begin
      h = $urandom_range(2, 200);
      seg(1, h); seg(0, 6);
      chk("R9 continuous high width", cap_o, h);
      chk("R9 continuous running", busy_o, 1);
    end

    // R6 low width
    for (int i = 0; i < 3; i++) begin
      l = $urandom_range(1, 250);
      meas_setup(1, 0, 1);
      seg(0, l); seg(1, 6);
      chk("R6 low width", cap_o, l);
    end

    // R7 rising-to-rising, continuous
    meas_setup(2, 1, 0);
    seg(1, 5);
    for (int i = 0; i < 3; i++) begin
      ex = $urandom_range(0, 100); l = $urandom_range(3, 100);
      seg(1, ex); seg(0, l); seg(1, 5);
      chk("R7 rise period", cap_o, 5 + ex + l);
    end
    // R7 falling-to-falling
    meas_setup(3, 1, 1);
    seg(0, 5);
    for (int i = 0; i < 3; i++) begin
      ex = $urandom_range(0, 100); h = $urandom_range(3, 100);
      seg(0, ex); seg(1, h); seg(0, 5);
      chk("R7 fall period", cap_o, 5 + ex + h);
    end

    // R8 combined high width and period
    meas_setup(4, 1, 0);
    seg(1, 5);
    for (int i = 0; i < 4; i++) begin
      ex = $urandom_range(0, 100); l = $urandom_range(3, 100);
      seg(1, ex); seg(0, l); seg(1, 5);
      chk("R8 combined width", cap_o, 5 + ex);
      chk("R8 combined period", cap2_o, 5 + ex + l);
    end

    // R10 boundary and saturation
    meas_setup(0, 0, 0);
    seg(1, 255); seg(0, 6);
    chk("R10 exact 255", cap_o, 255);
    chk("R10 no ovf at 255", ovf_o, 0);
    meas_setup(0, 0, 0);
    seg(1, 300); seg(0, 6);
    chk("R10 saturated", cap_o, sat8(300));
    chk("R10 ovf set", ovf_o, 1);
    tick_n(10);
    chk("R10 ovf sticky", ovf_o, 1);
    wr(2'd2, 8'h04);
    chk("R11 clear drops ovf", ovf_o, 0);
    chk("R11 clear drops irq", irq_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule